// File: doc/BRIEF.md
# Processor Bus Slave with Byte-Lane Parity

This block is a synchronous slave on a processor bus. An external master reaches a small internal register bank through it. On each rising clock edge the slave samples a start strobe together with the address, the read/write flag, the transfer size and the burst controls. One cycle later it answers with one of three active-low strobes: acknowledge, transfer error or retry. Write data arrives with one odd parity bit per byte lane, and the slave checks it. Read data leaves with freshly generated parity.

The data bus width is fixed when the block is built, at 8, 16 or 32 bits. Byte, half-word and word transfers are decoded from a 2-bit size code. A burst is started by holding the active-low burst flag low with the start strobe. It then runs four word beats at consecutive word addresses. After the first beat, each beat is taken in a cycle where the master holds the beat-request input high. Dropping that input early aborts the rest of the burst. Two test inputs force a retry or a transfer error on a new transfer.

Top module: `procbus_slave`

## Requirements
- R1: While rst_n is low, ack_n, err_n and retry_n are high, rdata and rpar are zero, and every register word is cleared to zero.
- R2: A start sampled on a rising edge produces exactly one response one clock later: ack_n, err_n or retry_n low for one cycle. No two of them are ever low together.
- R3: Size code 00 selects a word, 01 a byte and 10 a half-word. Address bits [1:0] give the byte offset k in the word, and offset k is bits [31-8k:24-8k] of the register word. On a bus of LANES bytes, byte k travels on data bits [8(LANES-1-k%LANES)+7 : 8(LANES-1-k%LANES)]. A read returns the LANES bytes that start at offset (k/LANES)*LANES.
- R4: The slave answers with err_n instead of ack_n, and performs no write, when any of these holds: size code 11, a size wider than the bus, a half-word at an odd offset, a word at a nonzero offset, or a word index (address bits above bit 1) of REGS or more.
- R5: Parity is odd. Parity bit i covers data bits [8i+7:8i]. A write whose parity is wrong on a lane that carries an enabled byte gets err_n and changes no register. Parity on lanes that carry no enabled byte is ignored.
- R6: rdata and rpar are zero except in the cycle that acknowledges a read. In that cycle each rpar bit is the odd parity of its data lane.
- R7: A start with burst_n low and word size starts a burst of four beats at word index base, base+1, base+2 and base+3. Beat 0 is taken with the start. Each later beat is taken in a cycle with beat_req high, and each beat gets its own acknowledge one cycle later. Write beats take the data present in their cycle. The slave returns to idle after beat 3.
- R8: If beat_req is low in any cycle during a burst, the burst ends without a response, and later beats neither write nor return data.
- R9: A start with burst_n low and a size other than word gets err_n and does not enter a burst.
- R10: inj_retry high with a start gives retry_n low with no access and no burst, and it wins over every error. inj_error high with a start gives err_n. Both inputs are ignored during burst beats.
- R11: With no start and no burst in progress, all three response strobes stay high, and beat_req has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transfer start strobe |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address (low bits of the master address) |
| size_i | input | 2 | Transfer size: 00 word, 01 byte, 10 half-word |
| burst_n_i | input | 1 | Low with start to request a four-beat burst |
| beat_req_i | input | 1 | High requests the next burst beat; low aborts the burst |
| wdata_i | input | BUS_W | Write data |
| wpar_i | input | BUS_W/8 | Odd parity of write data, one bit per lane |
| inj_error_i | input | 1 | Test: force a transfer error on this start |
| inj_retry_i | input | 1 | Test: force a retry on this start |
| rdata_o | output | BUS_W | Read data, valid with acknowledge |
| rpar_o | output | BUS_W/8 | Odd parity of read data |
| ack_n_o | output | 1 | Active-low acknowledge |
| err_n_o | output | 1 | Active-low transfer error |
| retry_n_o | output | 1 | Active-low retry request |

## Verification
The bench builds two copies of the block. One uses a 32-bit bus, where all four lanes carry data and whole words, odd offsets and bursts can be reached. The other uses an 8-bit bus, where every byte shares lane 0 and its parity bit, and where any half-word or word transfer must fail as too wide. Both copies keep 16 register words, so a word index of 16 reaches the out-of-range error.

// File: rtl/procbus_slave.sv
module procbus_slave #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 18,
  parameter int REGS   = 16,
  parameter int BEATS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 write_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic                 burst_n_i,
  input  logic                 beat_req_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic [BUS_W/8-1:0]   wpar_i,
  input  logic                 inj_error_i,
  input  logic                 inj_retry_i,
  output logic [BUS_W-1:0]     rdata_o,
  output logic [BUS_W/8-1:0]   rpar_o,
  output logic                 ack_n_o,
  output logic                 err_n_o,
  output logic                 retry_n_o
);
  localparam int LANES  = BUS_W / 8;
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(REGS);
  localparam int BEAT_W = $clog2(BEATS);

  logic [31:0]        regs [REGS];
  logic               bursting_q, wr_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [WORD_W-1:0]  base_q;

  logic [WORD_W-1:0]  cur_word;
  logic [1:0]         cur_off, cur_size;
  logic               cur_wr, go, fail, retry_hit, ok;
  logic               size_bad, range_bad, burst_bad, par_bad;
  logic [3:0]         byte_en;
  logic [LANES-1:0]   lane_en;
  logic [BUS_W-1:0]   rd_bus;
  logic [LANES-1:0]   rd_par;
  logic [31:0]        rword;
  int                 nbytes, rbase;

  assign cur_word = bursting_q ? base_q + WORD_W'(beat_q) : addr_i[ADDR_W-1:2];
  assign cur_off  = bursting_q ? 2'b00 : addr_i[1:0];
  assign cur_size = bursting_q ? 2'b00 : size_i;
  assign cur_wr   = bursting_q ? wr_q : write_i;
  assign go       = bursting_q ? beat_req_i : start_i;
  assign rword    = regs[cur_word[IDX_W-1:0]];

  always_comb begin
    case (cur_size)
      2'b00:   nbytes = 4;
      2'b01:   nbytes = 1;
      2'b10:   nbytes = 2;
      default: nbytes = 0;
    endcase
    size_bad = (nbytes == 0) || (nbytes > LANES);
    if (nbytes != 0)
      if ((int'(cur_off) % nbytes) != 0) size_bad = 1'b1;
    range_bad = cur_word >= WORD_W'(REGS);
    burst_bad = !bursting_q && !burst_n_i && (cur_size != 2'b00);
    byte_en = '0;
    lane_en = '0;
    for (int b = 0; b < 4; b++) begin
      byte_en[b] = (b >= int'(cur_off)) && (b < int'(cur_off) + nbytes);
      if (byte_en[b]) lane_en[LANES-1-(b%LANES)] = 1'b1;
    end
    par_bad = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (lane_en[i] && !(^{wdata_i[8*i+:8], wpar_i[i]})) par_bad = 1'b1;
    rbase = (int'(cur_off) / LANES) * LANES;
    for (int l = 0; l < LANES; l++)
      rd_bus[8*(LANES-1-l)+:8] = rword[8*(3-((rbase+l)%4))+:8];
    for (int i = 0; i < LANES; i++)
      rd_par[i] = ~^rd_bus[8*i+:8];
  end

  assign retry_hit = go && !bursting_q && inj_retry_i;
  assign fail      = (!bursting_q && inj_error_i) || size_bad || range_bad ||
                     burst_bad || (cur_wr && par_bad);
  assign ok        = go && !retry_hit && !fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_n_o    <= 1'b1;
      err_n_o    <= 1'b1;
      retry_n_o  <= 1'b1;
      rdata_o    <= '0;
      rpar_o     <= '0;
      bursting_q <= 1'b0;
      wr_q       <= 1'b0;
      beat_q     <= '0;
      base_q     <= '0;
      for (int r = 0; r < REGS; r++) regs[r] <= '0;
    end else begin
      ack_n_o   <= !ok;
      err_n_o   <= !(go && !retry_hit && fail);
      retry_n_o <= !retry_hit;
      rdata_o   <= (ok && !cur_wr) ? rd_bus : '0;
      rpar_o    <= (ok && !cur_wr) ? rd_par : '0;
      if (ok && cur_wr)
        for (int b = 0; b < 4; b++)
          if (byte_en[b])
            regs[cur_word[IDX_W-1:0]][8*(3-b)+:8] <= wdata_i[8*(LANES-1-(b%LANES))+:8];
      if (!bursting_q) begin
        if (ok && !burst_n_i) begin
          bursting_q <= 1'b1;
          beat_q     <= BEAT_W'(1);
          base_q     <= cur_word;
          wr_q       <= write_i;
        end
      end else if (!ok || beat_q == BEAT_W'(BEATS-1)) begin
        bursting_q <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!ack_n_o, !err_n_o, !retry_n_o}) <= 1); // R2
  AST_RETRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_n_o |-> $past(start_i && inj_retry_i && !bursting_q)); // R10
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bursting_q && !beat_req_i) |=> (ack_n_o && err_n_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bursting_q && !start_i) |=> (ack_n_o && err_n_o && retry_n_o)); // R11
  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n_o |-> (rdata_o == '0 && rpar_o == '0)); // R6
  AST_BAD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bursting_q && start_i && write_i && !inj_retry_i && par_bad) |=> !err_n_o); // R5
  AST_BEAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bursting_q |-> beat_q != '0); // R7
endmodule

// File: tb/procbus_slave_test.sv
module procbus_slave_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        start = 0, start8 = 0, wr = 0, burst_n = 1, beat_req = 0, inj_e = 0, inj_r = 0;
  logic [17:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wpar = '0;
  logic [7:0]  wdata8 = '0;
  logic        wpar8 = 0;
  logic [31:0] rdata;
  logic [3:0]  rpar;
  logic        ack_n, err_n, rty_n;
  logic [7:0]  rdata8;
  logic        rpar8, ack8_n, err8_n, rty8_n;
  int checks = 0, errors = 0;

  procbus_slave #(.BUS_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr), .addr_i(addr),
    .size_i(size), .burst_n_i(burst_n), .beat_req_i(beat_req), .wdata_i(wdata),
    .wpar_i(wpar), .inj_error_i(inj_e), .inj_retry_i(inj_r), .rdata_o(rdata),
    .rpar_o(rpar), .ack_n_o(ack_n), .err_n_o(err_n), .retry_n_o(rty_n));

  procbus_slave #(.BUS_W(8)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .start_i(start8), .write_i(wr), .addr_i(addr),
    .size_i(size), .burst_n_i(burst_n), .beat_req_i(beat_req), .wdata_i(wdata8),
    .wpar_i(wpar8), .inj_error_i(inj_e), .inj_retry_i(inj_r), .rdata_o(rdata8),
    .rpar_o(rpar8), .ack_n_o(ack8_n), .err_n_o(err8_n), .retry_n_o(rty8_n));

  function automatic logic [3:0] op32(input logic [31:0] d);
    for (int i = 0; i < 4; i++) op32[i] = ~^d[8*i+:8];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // response code: 0 ack, 1 error, 2 retry
  task automatic chk_resp(input string req, input int rsp);
    chk(req, {29'd0, ack_n, err_n, rty_n},
        rsp == 0 ? 32'b011 : rsp == 1 ? 32'b101 : rsp == 2 ? 32'b110 : 32'b111);
  endtask

  task automatic single(input logic w, input logic [1:0] s, input logic [17:0] a,
                        input logic [31:0] d, input logic [3:0] bad);
    @(negedge clk);
    start = 1; wr = w; size = s; addr = a; wdata = d; wpar = op32(d) ^ bad;
    @(negedge clk);
    start = 0; inj_e = 0; inj_r = 0;
  endtask

  typedef struct packed {
    logic        w;
    logic [1:0]  sz;
    logic [7:0]  ad;
    logic [31:0] wd;
    logic [3:0]  bad;
    logic [1:0]  rsp;
    logic [31:0] rd;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{1'b1, 2'b00, 8'h04, 32'h11223344, 4'h0, 2'd0, 32'h0},        // R3 word write
    '{1'b0, 2'b00, 8'h04, 32'h0,        4'h0, 2'd0, 32'h11223344}, // R3 R6
    '{1'b1, 2'b01, 8'h05, 32'h00AA0000, 4'h0, 2'd0, 32'h0},        // R3 byte lane
    '{1'b0, 2'b00, 8'h04, 32'h0,        4'h0, 2'd0, 32'h11AA3344},
    '{1'b1, 2'b10, 8'h06, 32'h0000BEEF, 4'h0, 2'd0, 32'h0},        // R3 half
    '{1'b0, 2'b10, 8'h06, 32'h0,        4'h0, 2'd0, 32'h11AABEEF},
    '{1'b1, 2'b00, 8'h04, 32'h55555555, 4'h1, 2'd1, 32'h0},        // R5 bad lane
    '{1'b0, 2'b00, 8'h04, 32'h0,        4'h0, 2'd0, 32'h11AABEEF}, // R5 no write
    '{1'b1, 2'b01, 8'h07, 32'h000000FF, 4'h8, 2'd0, 32'h0},        // R5 unused lane
    '{1'b0, 2'b00, 8'h04, 32'h0,        4'h0, 2'd0, 32'h11AABEFF},
    '{1'b1, 2'b10, 8'h05, 32'h00FFFF00, 4'h0, 2'd1, 32'h0},        // R4 odd half
    '{1'b1, 2'b00, 8'h06, 32'hFFFFFFFF, 4'h0, 2'd1, 32'h0},        // R4 offset word
    '{1'b0, 2'b11, 8'h04, 32'h0,        4'h0, 2'd1, 32'h0},        // R4 size 11
    '{1'b0, 2'b00, 8'h40, 32'h0,        4'h0, 2'd1, 32'h0},        // R4 range
    '{1'b0, 2'b00, 8'h08, 32'h0,        4'h0, 2'd0, 32'h0}         // R1 cleared
  };

  logic done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {29'd0, ack_n, err_n, rty_n}, 32'b111);
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset rpar", {28'd0, rpar}, 32'h0);
    rst_n = 1;

    foreach (TBL[i]) begin
      single(TBL[i].w, TBL[i].sz, {10'd0, TBL[i].ad}, TBL[i].wd, TBL[i].bad);
      chk_resp($sformatf("R2/R4 vector %0d response", i), TBL[i].rsp);
      chk($sformatf("R3/R6 vector %0d rdata", i), rdata, TBL[i].rd);
      chk($sformatf("R6 vector %0d rpar", i), {28'd0, rpar},
          (TBL[i].rsp == 0 && !TBL[i].w) ? {28'd0, op32(TBL[i].rd)} : 32'd0);
      @(negedge clk);
      chk_resp("R2 single response only", 3);
    end

    // R11 beat_req with no transfer
    @(negedge clk); beat_req = 1;
    @(negedge clk); beat_req = 0;
    chk_resp("R11 idle beat_req ignored", 3);

    // R10 retry wins, no access
    inj_r = 1; inj_e = 1;
    single(1, 2'b00, 18'h08, 32'hDEADBEEF, 4'h0);
    chk_resp("R10 retry", 2);
    single(0, 2'b00, 18'h08, 0, 4'h0);
    chk("R10 retry did not write", rdata, 32'h0);
    inj_e = 1;
    single(0, 2'b00, 18'h04, 0, 4'h0);
    chk_resp("R10 injected error", 1);

    // R7 burst write words 4..7
    @(negedge clk);
    start = 1; wr = 1; size = 2'b00; addr = 18'h10; burst_n = 0;
    wdata = 32'hA0000000; wpar = op32(wdata);
    for (int b = 1; b < 5; b++) begin
      @(negedge clk);
      start = 0; burst_n = 1; beat_req = (b < 4);
      wdata = 32'hA0000000 + b; wpar = op32(wdata);
      chk_resp($sformatf("R7 burst write beat %0d", b - 1), 0);
    end
    beat_req = 0;
    @(negedge clk);
    chk_resp("R7 burst ends after four beats", 3);
    // R7 burst read
    @(negedge clk);
    start = 1; wr = 0; addr = 18'h10; burst_n = 0;
    for (int b = 1; b < 5; b++) begin
      @(negedge clk);
      start = 0; burst_n = 1; beat_req = (b < 4);
      chk_resp($sformatf("R7 burst read beat %0d", b - 1), 0);
      chk($sformatf("R7 burst read data %0d", b - 1), rdata, 32'hA0000000 + b - 1);
      chk($sformatf("R6 burst read parity %0d", b - 1), {28'd0, rpar},
          {28'd0, op32(32'hA0000000 + b - 1)});
    end
    beat_req = 0;

    // R8 abort after two beats
    @(negedge clk);
    start = 1; wr = 1; addr = 18'h20; burst_n = 0;
    wdata = 32'h0000AAAA; wpar = op32(wdata);
    @(negedge clk);
    start = 0; burst_n = 1; beat_req = 1;
    wdata = 32'h0000BBBB; wpar = op32(wdata);
    chk_resp("R8 beat 0", 0);
    @(negedge clk);
    beat_req = 0; wdata = 32'h0000CCCC; wpar = op32(wdata);
    chk_resp("R8 beat 1", 0);
    @(negedge clk);
    chk_resp("R8 abort no response", 3);
    single(0, 2'b00, 18'h20, 0, 4'h0);
    chk("R8 word 8", rdata, 32'h0000AAAA);
    single(0, 2'b00, 18'h24, 0, 4'h0);
    chk("R8 word 9", rdata, 32'h0000BBBB);
    single(0, 2'b00, 18'h28, 0, 4'h0);
    chk("R8 word 10 untouched", rdata, 32'h0);

    // R9 burst with byte size
    @(negedge clk);
    start = 1; wr = 0; size = 2'b01; addr = 18'h30; burst_n = 0;
    @(negedge clk);
    start = 0; burst_n = 1; beat_req = 1;
    chk_resp("R9 burst non-word error", 1);
    @(negedge clk);
    beat_req = 0;
    chk_resp("R9 no burst entered", 3);

    // Narrow 8-bit bus: R3 R4 R5
    @(negedge clk);
    start8 = 1; wr = 1; size = 2'b01; addr = 18'h0D; wdata8 = 8'h5A; wpar8 = ~^8'h5A;
    @(negedge clk); start8 = 0;
    chk("R3 narrow byte write ack", {29'd0, ack8_n, err8_n, rty8_n}, 32'b011);
    start8 = 1; wr = 1; size = 2'b01; addr = 18'h0D; wdata8 = 8'h33; wpar8 = ^8'h33;
    @(negedge clk); start8 = 0;
    chk("R5 narrow bad parity", {29'd0, ack8_n, err8_n, rty8_n}, 32'b101);
    start8 = 1; wr = 0; size = 2'b01; addr = 18'h0D;
    @(negedge clk); start8 = 0;
    chk("R3 narrow byte read", {23'd0, rpar8, rdata8}, {23'd0, 1'b1, 8'h5A});
    start8 = 1; wr = 0; size = 2'b10; addr = 18'h0C;
    @(negedge clk); start8 = 0;
    chk("R4 narrow half too wide", {29'd0, ack8_n, err8_n, rty8_n}, 32'b101);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule